// File: doc/BRIEF.md
# Debounced Charger Interrupt Controller

This block sits between six already-synchronised comparator flags of a battery charger and the host interrupt line. The flags are charger attach, input overvoltage, reverse current, short circuit while supplying in reverse, constant-current/constant-voltage phase, and low charge current. Each flag is debounced against a time base of one `tick` pulse per microsecond. A flag's filtered level changes only after the raw flag has held its new value for that source's window. Each source has its own window and its own rule for which edges raise an interrupt.

Every source has three bits: a sense bit (the filtered level), a sticky pending bit and a mask bit. The host reaches these bits through a small register port. Writing the pending register clears the bits written as one. Writing the mask register replaces all masks. Reads are combinational by address. A single request output is raised while any unmasked source is pending.

Top module: `chg_irq_top`

## Requirements
- R1: Bit positions in every register: 0 charger attach, 1 overvoltage, 2 reverse current, 3 reverse short, 4 CC/CV phase (sense 0 = constant current, 1 = constant voltage), 5 low charge current. A sense bit takes the raw flag's value only after the flag has differed from it for the full window of its direction, counted in `tick` pulses. A window of 0 applies on the next clock.
- R2: When a raw flag returns to the sense value before the window ends, the count restarts from zero. The sense bit does not change and no interrupt is raised.
- R3: A sense change sets the pending bit only for the allowed edges. Attach, overvoltage and CC/CV set on both edges. Reverse current and reverse short set on the rising edge only. Low charge current sets on the falling edge only.
- R4: The overvoltage source uses window `OV_RISE_WIN` on rising changes and `OV_FALL_WIN` (default 0) on falling changes.
- R5: The reverse-short source uses `SHORT_HI_WIN` in both directions while `shortThrSel` is 1, and `SHORT_LO_WIN` while it is 0.
- R6: While `regEnable` is 0, the low-current sense bit is 1, its count is held at zero and it raises no interrupt. After `regEnable` rises, a low raw flag must hold for the full window before the bit falls.
- R7: A write to address 0 clears each pending bit whose data bit is 1. Pending bits written with 0 keep their value.
- R8: A new event in the same cycle as a clear of the same bit leaves the bit pending.
- R9: A write to address 1 loads all mask bits. A masked pending bit stays pending but does not drive `irqOut`.
- R10: `irqOut` is 1 exactly when some pending bit has its mask bit at 0.
- R11: After reset the pending bits are 0, the mask bits are all 1, `irqOut` is 0, and the sense bits are 0 except the low-current bit, which is 1.
- R12: `rdData` shows the pending bits for address 0, the masks for address 1, the sense bits for address 2, and 0 for address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per microsecond |
| flagIn | input | 6 | Synchronised raw comparator flags |
| regEnable | input | 1 | Charge path regulator enabled |
| shortThrSel | input | 1 | Selects the long short-circuit window |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address |
| wrData | input | 6 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 6 | Read data |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The bench shrinks the windows to attach 12, overvoltage rise 8 and fall 0, reverse current 6, short 3 or 9, CC/CV 20 and low current 10 ticks. This puts every expiry, restart and edge-rule case within a few thousand cycles. At these sizes, random flag flips and gaps in `tick` produce glitches both just shorter and just longer than each window. They also produce clears that land on the same cycle as a new event, and threshold switches in the middle of a count. The real microsecond windows differ only in counter width.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;
  localparam int NSRC = 6;

  localparam int SRC_ATTACH = 0;
  localparam int SRC_OVERV  = 1;
  localparam int SRC_REVCUR = 2;
  localparam int SRC_SHORT  = 3;
  localparam int SRC_CCCV   = 4;
  localparam int SRC_LOWCUR = 5;

  // edge rules: which sense transitions raise a pending bit
  localparam logic [NSRC-1:0] RISE_EN   = 6'b011111;
  localparam logic [NSRC-1:0] FALL_EN   = 6'b110011;
  localparam logic [NSRC-1:0] SENSE_RST = 6'b100000;

  localparam logic [1:0] ADR_PEND  = 2'd0;
  localparam logic [1:0] ADR_MASK  = 2'd1;
  localparam logic [1:0] ADR_SENSE = 2'd2;

  typedef struct packed {
    logic [NSRC-1:0] clrPend;
    logic            maskWe;
    logic [NSRC-1:0] maskVal;
  } ctrlStrb_t;

  function automatic int unsigned maxU(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/chg_irq_filter.sv
module chg_irq_filter #(
  parameter int   CW        = 8,
  parameter logic RST_LEVEL = 1'b0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          rawIn,
  input  logic          forceOn,
  input  logic [CW-1:0] riseWin,
  input  logic [CW-1:0] fallWin,
  output logic          levelOut,
  output logic          riseEvt,
  output logic          fallEvt
);
  logic [CW-1:0] cntQ;
  logic          levelQ;
  logic [CW-1:0] winSel;
  logic [CW:0]   cntNext;
  logic          differ;
  logic          expire;

  always_comb begin
    differ  = (rawIn != levelQ);
    winSel  = rawIn ? riseWin : fallWin;
    cntNext = {1'b0, cntQ} + 1'b1;
    expire  = differ && !forceOn &&
              ((winSel == '0) || (tick && (cntNext >= {1'b0, winSel})));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ <= RST_LEVEL;
      cntQ   <= '0;
    end else if (forceOn) begin
      levelQ <= 1'b1;
      cntQ   <= '0;
    end else if (!differ) begin
      cntQ <= '0;
    end else if (expire) begin
      levelQ <= rawIn;
      cntQ   <= '0;
    end else if (tick) begin
      cntQ <= cntNext[CW-1:0];
    end
  end

  assign levelOut = levelQ;
  assign riseEvt  = expire && rawIn;
  assign fallEvt  = expire && !rawIn;

  // R2: the level moves only after the raw flag disagreed with it
  assert_level_needs_differ_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(levelQ) |-> ($past(differ) || $past(forceOn)));

  // R1: a non-forced change needs a tick unless the window is zero
  assert_level_needs_tick_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(levelQ) && !$past(forceOn)) |-> ($past(tick) || ($past(winSel) == '0)));
endmodule

// File: rtl/chg_irq_ctrl.sv
module chg_irq_ctrl
  import chg_irq_pkg::*;
(
  input  logic            wrEn,
  input  logic [1:0]      wrAddr,
  input  logic [NSRC-1:0] wrData,
  input  logic [1:0]      rdAddr,
  input  logic [NSRC-1:0] pendIn,
  input  logic [NSRC-1:0] maskIn,
  input  logic [NSRC-1:0] senseIn,
  output ctrlStrb_t       strb,
  output logic [NSRC-1:0] rdData
);
  always_comb begin
    strb.clrPend = (wrEn && (wrAddr == ADR_PEND)) ? wrData : '0;
    strb.maskWe  = wrEn && (wrAddr == ADR_MASK);
    strb.maskVal = wrData;
  end

  always_comb begin
    case (rdAddr)
      ADR_PEND:  rdData = pendIn;
      ADR_MASK:  rdData = maskIn;
      ADR_SENSE: rdData = senseIn;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/chg_irq_datapath.sv
module chg_irq_datapath
  import chg_irq_pkg::*;
#(
  parameter int unsigned ATTACH_WIN   = 32000,
  parameter int unsigned OV_RISE_WIN  = 7800,
  parameter int unsigned OV_FALL_WIN  = 0,
  parameter int unsigned REV_WIN      = 2900,
  parameter int unsigned SHORT_LO_WIN = 150,
  parameter int unsigned SHORT_HI_WIN = 2900,
  parameter int unsigned CCCV_WIN     = 2000000,
  parameter int unsigned LOWCUR_WIN   = 16000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick,
  input  logic [NSRC-1:0] flagIn,
  input  logic            regEnable,
  input  logic            shortThrSel,
  input  ctrlStrb_t       strb,
  output logic [NSRC-1:0] pendOut,
  output logic [NSRC-1:0] maskOut,
  output logic [NSRC-1:0] senseOut,
  output logic            irqOut
);
  localparam int unsigned WMAX = maxU(maxU(maxU(ATTACH_WIN, OV_RISE_WIN), maxU(OV_FALL_WIN, REV_WIN)),
                                      maxU(maxU(SHORT_LO_WIN, SHORT_HI_WIN), maxU(CCCV_WIN, LOWCUR_WIN)));
  localparam int CW = $clog2(WMAX + 1);

  logic [CW-1:0]   riseWin [NSRC];
  logic [CW-1:0]   fallWin [NSRC];
  logic [NSRC-1:0] riseEvt, fallEvt, evt, forceOn;
  logic [NSRC-1:0] pendQ, maskQ;

  always_comb begin
    riseWin[SRC_ATTACH] = CW'(ATTACH_WIN);
    fallWin[SRC_ATTACH] = CW'(ATTACH_WIN);
    riseWin[SRC_OVERV]  = CW'(OV_RISE_WIN);
    fallWin[SRC_OVERV]  = CW'(OV_FALL_WIN);
    riseWin[SRC_REVCUR] = CW'(REV_WIN);
    fallWin[SRC_REVCUR] = CW'(REV_WIN);
    riseWin[SRC_SHORT]  = shortThrSel ? CW'(SHORT_HI_WIN) : CW'(SHORT_LO_WIN);
    fallWin[SRC_SHORT]  = shortThrSel ? CW'(SHORT_HI_WIN) : CW'(SHORT_LO_WIN);
    riseWin[SRC_CCCV]   = CW'(CCCV_WIN);
    fallWin[SRC_CCCV]   = CW'(CCCV_WIN);
    riseWin[SRC_LOWCUR] = CW'(LOWCUR_WIN);
    fallWin[SRC_LOWCUR] = CW'(LOWCUR_WIN);
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign forceOn[i] = (i == SRC_LOWCUR) ? !regEnable : 1'b0;

    chg_irq_filter #(
      .CW        (CW),
      .RST_LEVEL (SENSE_RST[i])
    ) u_filter (
      .clk      (clk),
      .rstN     (rstN),
      .tick     (tick),
      .rawIn    (flagIn[i]),
      .forceOn  (forceOn[i]),
      .riseWin  (riseWin[i]),
      .fallWin  (fallWin[i]),
      .levelOut (senseOut[i]),
      .riseEvt  (riseEvt[i]),
      .fallEvt  (fallEvt[i])
    );
  end

  assign evt = (riseEvt & RISE_EN) | (fallEvt & FALL_EN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      maskQ <= '1;
    end else begin
      pendQ <= (pendQ & ~strb.clrPend) | evt;
      if (strb.maskWe) maskQ <= strb.maskVal;
    end
  end

  assign pendOut = pendQ;
  assign maskOut = maskQ;
  assign irqOut  = |(pendQ & ~maskQ);

  for (genvar b = 0; b < NSRC; b++) begin : g_chk
    // R3: a pending bit is only raised by a qualifying filtered edge
    assert_pend_set_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pendQ[b]) |-> $past(evt[b]));
    // R7, R8: a pending bit drops only on a clear with no same-cycle event
    assert_pend_clear_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
      $fell(pendQ[b]) |-> ($past(strb.clrPend[b]) && !$past(evt[b])));
  end

  // R9: masks change only through a mask write
  assert_mask_write_only_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(maskQ) |-> $past(strb.maskWe));

  // R10: a request always has something pending behind it
  assert_irq_has_pend_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (pendQ != '0));
endmodule

// File: rtl/chg_irq_top.sv
module chg_irq_top
  import chg_irq_pkg::*;
#(
  parameter int unsigned ATTACH_WIN   = 32000,
  parameter int unsigned OV_RISE_WIN  = 7800,
  parameter int unsigned OV_FALL_WIN  = 0,
  parameter int unsigned REV_WIN      = 2900,
  parameter int unsigned SHORT_LO_WIN = 150,
  parameter int unsigned SHORT_HI_WIN = 2900,
  parameter int unsigned CCCV_WIN     = 2000000,
  parameter int unsigned LOWCUR_WIN   = 16000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [5:0] flagIn,
  input  logic       regEnable,
  input  logic       shortThrSel,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [5:0] wrData,
  input  logic [1:0] rdAddr,
  output logic [5:0] rdData,
  output logic       irqOut
);
  ctrlStrb_t       strb;
  logic [NSRC-1:0] pendW, maskW, senseW;

  chg_irq_ctrl u_ctrl (
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .pendIn  (pendW),
    .maskIn  (maskW),
    .senseIn (senseW),
    .strb    (strb),
    .rdData  (rdData)
  );

  chg_irq_datapath #(
    .ATTACH_WIN   (ATTACH_WIN),
    .OV_RISE_WIN  (OV_RISE_WIN),
    .OV_FALL_WIN  (OV_FALL_WIN),
    .REV_WIN      (REV_WIN),
    .SHORT_LO_WIN (SHORT_LO_WIN),
    .SHORT_HI_WIN (SHORT_HI_WIN),
    .CCCV_WIN     (CCCV_WIN),
    .LOWCUR_WIN   (LOWCUR_WIN)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .tick        (tick),
    .flagIn      (flagIn),
    .regEnable   (regEnable),
    .shortThrSel (shortThrSel),
    .strb        (strb),
    .pendOut     (pendW),
    .maskOut     (maskW),
    .senseOut    (senseW),
    .irqOut      (irqOut)
  );
endmodule

// File: tb/chg_irq_top_bench.sv
module chg_irq_top_bench;
  localparam int W_ATT = 12, W_OVR = 8, W_OVF = 0, W_REV = 6;
  localparam int W_SLO = 3, W_SHI = 9, W_CCV = 20, W_LOW = 10;
  localparam logic [5:0] RISE_OK = 6'b011111, FALL_OK = 6'b110011;

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b1, regEnable = 1'b1, shortThrSel = 1'b0;
  logic [5:0] flagIn = 6'b100000;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0, rdAddr = '0;
  logic [5:0] wrData = '0;
  logic [5:0] rdData;
  logic irqOut;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  chg_irq_top #(
    .ATTACH_WIN(W_ATT), .OV_RISE_WIN(W_OVR), .OV_FALL_WIN(W_OVF), .REV_WIN(W_REV),
    .SHORT_LO_WIN(W_SLO), .SHORT_HI_WIN(W_SHI), .CCCV_WIN(W_CCV), .LOWCUR_WIN(W_LOW)
  ) u_chg_irq_top (
    .clk(clk), .rstN(rstN), .tick(tick), .flagIn(flagIn), .regEnable(regEnable),
    .shortThrSel(shortThrSel), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irqOut(irqOut)
  );

  // reference model built from the requirements
  logic [5:0] mLvl, mPend, mMask;
  int mCnt [6];

  function automatic int winFor(int i, logic rising, logic thr);
    case (i)
      0: return W_ATT;
      1: return rising ? W_OVR : W_OVF;
      2: return W_REV;
      3: return thr ? W_SHI : W_SLO;
      4: return W_CCV;
      default: return W_LOW;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLvl <= 6'b100000; mPend <= '0; mMask <= '1;
      for (int i = 0; i < 6; i++) mCnt[i] <= 0;
    end else begin
      logic [5:0] nPend;
      int w;
      nPend = mPend;
      if (wrEn && wrAddr == 2'd0) nPend = nPend & ~wrData;
      if (wrEn && wrAddr == 2'd1) mMask <= wrData;
      for (int i = 0; i < 6; i++) begin
        w = winFor(i, flagIn[i], shortThrSel);
        if (i == 5 && !regEnable) begin
          mLvl[i] <= 1'b1; mCnt[i] <= 0;
        end else if (flagIn[i] != mLvl[i]) begin
          if (w == 0 || (tick && mCnt[i] + 1 >= w)) begin
            mLvl[i] <= flagIn[i]; mCnt[i] <= 0;
            if (flagIn[i] ? RISE_OK[i] : FALL_OK[i]) nPend[i] = 1'b1;
          end else if (tick) mCnt[i] <= mCnt[i] + 1;
        end else mCnt[i] <= 0;
      end
      mPend <= nPend;
    end
  end

  task automatic chk(input string tag, input logic [5:0] got, input logic [5:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [5:0] v);
    rdAddr = a; #1; v = rdData;
  endtask

  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [5:0] v;
    waitN(3);
    rstN = 1'b1;
    waitN(1);
    // R11 reset state, R12 address map
    rd(2'd0, v); chk("R11 pending after reset", v, 6'h00);
    rd(2'd1, v); chk("R11 mask after reset", v, 6'h3F);
    rd(2'd2, v); chk("R11 sense after reset", v, 6'h20);
    rd(2'd3, v); chk("R12 unused address", v, 6'h00);
    chk("R11 irq after reset", {5'd0, irqOut}, 6'h00);

    // R2 glitch one tick short of the window
    flagIn[2] = 1'b1; waitN(W_REV - 1); flagIn[2] = 1'b0; waitN(3);
    rd(2'd2, v); chk("R2 sense unchanged by short glitch", v, 6'h20);
    rd(2'd0, v); chk("R2 no pending from short glitch", v, 6'h00);

    // R1/R3 full window on a rising-only source, masked so no request (R9)
    flagIn[2] = 1'b1; waitN(W_REV);
    rd(2'd2, v); chk("R1 sense after full window", v, 6'h24);
    rd(2'd0, v); chk("R3 rising edge pends", v, 6'h04);
    chk("R9 masked pending gives no irq", {5'd0, irqOut}, 6'h00);
    wr(2'd1, 6'h3B);
    chk("R10 unmasked pending raises irq", {5'd0, irqOut}, 6'h01);

    // R7 write-one-to-clear
    wr(2'd0, 6'h01);
    rd(2'd0, v); chk("R7 zero bits keep pending", v, 6'h04);
    wr(2'd0, 6'h04);
    rd(2'd0, v); chk("R7 one bit clears pending", v, 6'h00);
    chk("R10 irq drops after clear", {5'd0, irqOut}, 6'h00);

    // R4 overvoltage asymmetric windows
    flagIn[1] = 1'b1; waitN(W_OVR);
    rd(2'd0, v); chk("R4 overvoltage rise after window", v, 6'h02);
    wr(2'd0, 6'h02);
    flagIn[1] = 1'b0; waitN(1);
    rd(2'd2, v); chk("R4 overvoltage fall immediate", v, 6'h24);
    rd(2'd0, v); chk("R4 falling edge also pends", v, 6'h02);
    wr(2'd0, 6'h02);

    // R3 falling edge on rising-only source
    flagIn[2] = 1'b0; waitN(W_REV + 1);
    rd(2'd2, v); chk("R3 reverse current level falls", v, 6'h20);
    rd(2'd0, v); chk("R3 falling edge ignored on rising-only source", v, 6'h00);

    // R5 short threshold window selection
    flagIn[3] = 1'b1; waitN(W_SLO);
    rd(2'd2, v); chk("R5 short low window", v, 6'h28);
    shortThrSel = 1'b1; flagIn[3] = 1'b0; waitN(W_SLO);
    rd(2'd2, v); chk("R5 long window still running", v, 6'h28);
    waitN(W_SHI - W_SLO);
    rd(2'd2, v); chk("R5 long window expired", v, 6'h20);
    wr(2'd0, 6'h3F);

    // R6 low-current forced while regulator off
    regEnable = 1'b0; flagIn[5] = 1'b0; waitN(W_LOW + 3);
    rd(2'd2, v); chk("R6 sense forced high", v, 6'h20);
    rd(2'd0, v); chk("R6 no pending while forced", v, 6'h00);
    regEnable = 1'b1; waitN(W_LOW - 1);
    rd(2'd2, v); chk("R6 window restarts on enable", v, 6'h20);
    waitN(1);
    rd(2'd2, v); chk("R6 sense falls after window", v, 6'h00);
    rd(2'd0, v); chk("R3 low-current falling edge pends", v, 6'h20);
    wr(2'd0, 6'h20);

    // R8 event and clear in the same cycle
    flagIn[0] = 1'b1; waitN(W_ATT - 1);
    wr(2'd0, 6'h01);
    rd(2'd0, v); chk("R8 event wins over clear", v, 6'h01);

    // random phase against the model
    for (int n = 0; n < 6000; n++) begin
      logic [1:0] a;
      a = 2'($urandom_range(0, 3));
      rd(a, v);
      case (a)
        2'd0: chk("R3 R7 R8 pending vs model", v, mPend);
        2'd1: chk("R9 mask vs model", v, mMask);
        2'd2: chk("R1 R2 R5 R6 sense vs model", v, mLvl);
        default: chk("R12 zero address", v, 6'h00);
      endcase
      chk("R10 irq vs model", {5'd0, irqOut}, {5'd0, |(mPend & ~mMask)});
      for (int i = 0; i < 6; i++)
        if ($urandom_range(0, 9) == 0) flagIn[i] = ~flagIn[i];
      tick = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 99) == 0) regEnable = ~regEnable;
      if ($urandom_range(0, 79) == 0) shortThrSel = ~shortThrSel;
      wrEn = ($urandom_range(0, 5) == 0);
      wrAddr = 2'($urandom_range(0, 3));
      wrData = 6'($urandom);
      @(negedge clk);
    end
    wrEn = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule